// File: doc/BRIEF.md
# Inbound Transaction Router

This block sits behind a simplified bus-target front end and decides, one request at a time, what happens to each inbound transaction. It looks at the 4-bit command code and at the flag that says which of the two ports the request came in on. From these it decides whether to claim the request. A claimed request goes down one of three paths: a posted-write queue, a single delayed-read slot, or a single delayed configuration-write slot. The block then masters the matching operation onto a simple request/grant internal bus.

The answer on the request channel is combinational and comes in the same cycle as the request. An unclaimed request sees all response flags low (a master abort). A claimed request is either accepted or told to retry. Posted writes are accepted as soon as there is room in the queue. Delayed reads and configuration writes are told to retry until the internal bus has returned their completion word. After that, a repeat of the same command and address is accepted, collects that word and frees the slot.

Top module: `inb_txn_router`

## Requirements
- R1: Only these command codes are claimed: 0110 memory read, 0111 memory write, 1010 configuration read, 1011 configuration write, 1100 read multiple, 1110 read line, 1111 write and invalidate. For any other code, rsp_claim, rsp_accept and rsp_retry stay low and no internal-bus operation results.
- R2: A configuration read (1010) or configuration write (1011) with req_secondary=1 is not claimed and leaves no state behind.
- R3: A write (0111 or 1111) is claimed and accepted in the same cycle while fewer than POST_DEPTH (4) writes are held. Held writes go out on the internal bus as ib_write=1, ib_cfg=0, in arrival order, with their address, data and byte enables unchanged. A posted write is complete when it is granted.
- R4: While POST_DEPTH writes are held, a new write is claimed but answered with rsp_retry, and nothing is stored.
- R5: A read (0110, 1110, 1100, or 1010 on the primary port) that finds the read slot empty is answered with retry and captured. It is issued as ib_write=0, with ib_cfg=1 only for code 1010. Once ib_rvalid has returned the word, the next request with the same command and address is accepted, rsp_rdata carries that word, and the slot is freed.
- R6: Only one delayed read is held at a time. A read with a different command or address is retried and not captured. A matching read that arrives before completion is also retried.
- R7: A primary-port configuration write uses its own single slot and follows the same rules. It is issued as ib_write=1, ib_cfg=1 with the captured data. On the accepting repeat, rsp_rdata carries the completion word from the internal bus.
- R8: A delayed read or configuration write is not put on the internal bus while any posted write is held.
- R9: Only one internal-bus operation is in flight at a time. After a delayed operation is granted, ib_req stays low until ib_rvalid returns.
- R10: After reset, ib_req is low, the queue and both slots are empty, and all response outputs are low while req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Command code |
| req_addr | input | AW | Request address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables |
| req_secondary | input | 1 | 1 when the request arrives on the secondary port |
| rsp_claim | output | 1 | Request is claimed |
| rsp_accept | output | 1 | Request completes this cycle |
| rsp_retry | output | 1 | Requester must retry |
| rsp_rdata | output | DW | Completion word on an accepted delayed request, else zero |
| ib_req | output | 1 | Internal-bus operation requested |
| ib_write | output | 1 | Operation is a write |
| ib_cfg | output | 1 | Operation targets configuration space |
| ib_addr | output | AW | Operation address |
| ib_wdata | output | DW | Operation write data |
| ib_be | output | DW/8 | Operation byte enables |
| ib_gnt | input | 1 | Internal bus takes the operation this cycle |
| ib_rvalid | input | 1 | Completion for the in-flight delayed operation |
| ib_rdata | input | DW | Completion word |

## Verification
The hardest case to reach is a delayed read that is captured while posted writes are still held and the internal bus is withholding grant. The read has to wait behind the writes and then be collected by a repeat. On the way, mismatching polls and new writes arrive during its wait for completion. The directed part holds ib_gnt low to fill the queue and capture the read, then releases grant and polls with a wrong address, a wrong read variant and finally the exact match. The random part confines delayed addresses to four values so that collisions, refusals and collections happen often, while grant is withheld a quarter of the time.

// File: rtl/inb_rtr_pkg.sv
package inb_rtr_pkg;

    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_RD_LINE = 4'b1110;
    localparam logic [3:0] CMD_WR_INV  = 4'b1111;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_POST,
        PATH_DRD,
        PATH_DCW
    } path_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_PEND,
        SLOT_ISSUED,
        SLOT_DONE
    } slot_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_WAIT
    } bus_e;

endpackage

// File: rtl/inb_cmd_classify.sv
module inb_cmd_classify
    import inb_rtr_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic       secondary,
    output path_e      path
);

    always_comb begin
        case (cmd)
            CMD_MEM_WR, CMD_WR_INV:               path = PATH_POST;
            CMD_MEM_RD, CMD_RD_LINE, CMD_RD_MULT: path = PATH_DRD;
            CMD_CFG_RD:                           path = secondary ? PATH_NONE : PATH_DRD;
            CMD_CFG_WR:                           path = secondary ? PATH_NONE : PATH_DCW;
            default:                              path = PATH_NONE;
        endcase
    end

endmodule

// File: rtl/inb_post_queue.sv
module inb_post_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 68
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr = (q_q.wr == LAST) ? '0 : q_q.wr + 1'b1;
        end
        if (pop) begin
            q_d.rd = (q_q.rd == LAST) ? '0 : q_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rd];
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign empty = (q_q.cnt == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/inb_delay_slot.sv
module inb_delay_slot
    import inb_rtr_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_hit,
    input  logic [3:0]     req_cmd,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    input  logic [BEW-1:0] req_be,
    input  logic           issue_take,
    input  logic           cpl_valid,
    input  logic [DW-1:0]  cpl_data,
    output logic           pend,
    output logic [3:0]     ent_cmd,
    output logic [AW-1:0]  ent_addr,
    output logic [DW-1:0]  ent_data,
    output logic [BEW-1:0] ent_be,
    output logic           rsp_accept,
    output logic           rsp_retry,
    output logic [DW-1:0]  rsp_rdata
);

    typedef struct packed {
        slot_e          st;
        logic [3:0]     cmd;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
        logic [DW-1:0]  ret;
    } slot_t;

    slot_t s_d, s_q;
    logic  match;

    always_comb begin
        s_d        = s_q;
        rsp_accept = 1'b0;
        rsp_retry  = 1'b0;
        match      = (req_cmd == s_q.cmd) && (req_addr == s_q.addr);
        if (req_hit) begin
            if (s_q.st == SLOT_EMPTY) begin
                s_d.st    = SLOT_PEND;
                s_d.cmd   = req_cmd;
                s_d.addr  = req_addr;
                s_d.data  = req_data;
                s_d.be    = req_be;
                rsp_retry = 1'b1;
            end else if ((s_q.st == SLOT_DONE) && match) begin
                s_d.st     = SLOT_EMPTY;
                rsp_accept = 1'b1;
            end else begin
                rsp_retry = 1'b1;
            end
        end
        if (issue_take && (s_q.st == SLOT_PEND)) begin
            s_d.st = SLOT_ISSUED;
        end
        if (cpl_valid && (s_q.st == SLOT_ISSUED)) begin
            s_d.st  = SLOT_DONE;
            s_d.ret = cpl_data;
        end
        rsp_rdata = rsp_accept ? s_q.ret : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend     = (s_q.st == SLOT_PEND);
    assign ent_cmd  = s_q.cmd;
    assign ent_addr = s_q.addr;
    assign ent_data = s_q.data;
    assign ent_be   = s_q.be;

    // R5
    done_needs_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.st == SLOT_DONE) |-> $past(cpl_valid));

    // R6
    held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SLOT_PEND) || (s_q.st == SLOT_ISSUED)) |=>
            ($stable(ent_addr) && $stable(ent_cmd)));

    // R9
    cpl_when_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (s_q.st == SLOT_ISSUED) || !issue_take);

endmodule

// File: rtl/inb_txn_router.sv
module inb_txn_router
    import inb_rtr_pkg::*;
#(
    parameter  int AW         = 32,
    parameter  int DW         = 32,
    parameter  int POST_DEPTH = 4,
    localparam int BEW        = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [3:0]     req_cmd,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    input  logic [BEW-1:0] req_be,
    input  logic           req_secondary,
    output logic           rsp_claim,
    output logic           rsp_accept,
    output logic           rsp_retry,
    output logic [DW-1:0]  rsp_rdata,
    output logic           ib_req,
    output logic           ib_write,
    output logic           ib_cfg,
    output logic [AW-1:0]  ib_addr,
    output logic [DW-1:0]  ib_wdata,
    output logic [BEW-1:0] ib_be,
    input  logic           ib_gnt,
    input  logic           ib_rvalid,
    input  logic [DW-1:0]  ib_rdata
);

    localparam int PQW = AW + DW + BEW;

    typedef struct packed {
        bus_e  st;
        path_e src;
    } bus_t;

    bus_t  bus_d, bus_q;
    path_e path;
    path_e sel;

    logic           post_hit, rd_hit, cw_hit;
    logic           pq_push, pq_pop, pq_full, pq_empty;
    logic [PQW-1:0] pq_head;
    logic [AW-1:0]  pq_addr;
    logic [DW-1:0]  pq_data;
    logic [BEW-1:0] pq_be;

    logic           rd_take, rd_cpl, rd_pend, rd_acc, rd_ret;
    logic [3:0]     rd_cmd;
    logic [AW-1:0]  rd_addr;
    logic [DW-1:0]  rd_data, rd_rdata;
    logic [BEW-1:0] rd_be;

    logic           cw_take, cw_cpl, cw_pend, cw_acc, cw_ret;
    logic [3:0]     cw_cmd;
    logic [AW-1:0]  cw_addr;
    logic [DW-1:0]  cw_data, cw_rdata;
    logic [BEW-1:0] cw_be;

    inb_cmd_classify u_classify (
        .cmd       (req_cmd),
        .secondary (req_secondary),
        .path      (path)
    );

    assign post_hit = req_valid && (path == PATH_POST);
    assign rd_hit   = req_valid && (path == PATH_DRD);
    assign cw_hit   = req_valid && (path == PATH_DCW);
    assign pq_push  = post_hit && !pq_full;

    inb_post_queue #(
        .DEPTH (POST_DEPTH),
        .W     (PQW)
    ) u_post_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (pq_push),
        .push_data ({req_addr, req_data, req_be}),
        .pop       (pq_pop),
        .head      (pq_head),
        .full      (pq_full),
        .empty     (pq_empty)
    );

    assign {pq_addr, pq_data, pq_be} = pq_head;

    inb_delay_slot #(
        .AW  (AW),
        .DW  (DW),
        .BEW (BEW)
    ) u_read_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_hit    (rd_hit),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_be     (req_be),
        .issue_take (rd_take),
        .cpl_valid  (rd_cpl),
        .cpl_data   (ib_rdata),
        .pend       (rd_pend),
        .ent_cmd    (rd_cmd),
        .ent_addr   (rd_addr),
        .ent_data   (rd_data),
        .ent_be     (rd_be),
        .rsp_accept (rd_acc),
        .rsp_retry  (rd_ret),
        .rsp_rdata  (rd_rdata)
    );

    inb_delay_slot #(
        .AW  (AW),
        .DW  (DW),
        .BEW (BEW)
    ) u_cfgw_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_hit    (cw_hit),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_be     (req_be),
        .issue_take (cw_take),
        .cpl_valid  (cw_cpl),
        .cpl_data   (ib_rdata),
        .pend       (cw_pend),
        .ent_cmd    (cw_cmd),
        .ent_addr   (cw_addr),
        .ent_data   (cw_data),
        .ent_be     (cw_be),
        .rsp_accept (cw_acc),
        .rsp_retry  (cw_ret),
        .rsp_rdata  (cw_rdata)
    );

    // Request-channel answer, same cycle as the request.
    always_comb begin
        rsp_claim  = req_valid && (path != PATH_NONE);
        rsp_accept = pq_push || rd_acc || cw_acc;
        rsp_retry  = (post_hit && pq_full) || rd_ret || cw_ret;
        rsp_rdata  = rd_acc ? rd_rdata : (cw_acc ? cw_rdata : '0);
    end

    // Internal-bus issue: posted writes first, then read slot, then config write.
    always_comb begin
        bus_d = bus_q;
        sel   = PATH_NONE;
        if (bus_q.st == BUS_IDLE) begin
            if (!pq_empty)    sel = PATH_POST;
            else if (rd_pend) sel = PATH_DRD;
            else if (cw_pend) sel = PATH_DCW;
        end

        ib_req   = (sel != PATH_NONE);
        ib_write = 1'b0;
        ib_cfg   = 1'b0;
        ib_addr  = '0;
        ib_wdata = '0;
        ib_be    = '0;
        case (sel)
            PATH_POST: begin
                ib_write = 1'b1;
                ib_addr  = pq_addr;
                ib_wdata = pq_data;
                ib_be    = pq_be;
            end
            PATH_DRD: begin
                ib_cfg   = (rd_cmd == CMD_CFG_RD);
                ib_addr  = rd_addr;
                ib_wdata = rd_data;
                ib_be    = rd_be;
            end
            PATH_DCW: begin
                ib_write = 1'b1;
                ib_cfg   = (cw_cmd == CMD_CFG_WR);
                ib_addr  = cw_addr;
                ib_wdata = cw_data;
                ib_be    = cw_be;
            end
            default: ;
        endcase

        pq_pop  = ib_req && ib_gnt && (sel == PATH_POST);
        rd_take = ib_req && ib_gnt && (sel == PATH_DRD);
        cw_take = ib_req && ib_gnt && (sel == PATH_DCW);
        rd_cpl  = (bus_q.st == BUS_WAIT) && ib_rvalid && (bus_q.src == PATH_DRD);
        cw_cpl  = (bus_q.st == BUS_WAIT) && ib_rvalid && (bus_q.src == PATH_DCW);

        if (rd_take || cw_take) begin
            bus_d.st  = BUS_WAIT;
            bus_d.src = sel;
        end else if ((bus_q.st == BUS_WAIT) && ib_rvalid) begin
            bus_d.st  = BUS_IDLE;
            bus_d.src = PATH_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '{st: BUS_IDLE, src: PATH_NONE};
        else        bus_q <= bus_d;
    end

    // R1
    unclaimed_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (path == PATH_NONE)) |-> (!rsp_claim && !rsp_accept && !rsp_retry));

    // R2
    secondary_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secondary && ((req_cmd == CMD_CFG_RD) || (req_cmd == CMD_CFG_WR)))
            |-> !rsp_claim);

    // R3
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_accept && rsp_retry));

    // R8
    posted_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !(ib_write && !ib_cfg)) |-> pq_empty);

    // R9
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_gnt && !(ib_write && !ib_cfg)) |=> !ib_req);

endmodule

// File: tb/tb_inb_txn_router.sv
`timescale 1ns/1ps
module tb_inb_txn_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_be = '0;
    logic        req_secondary = 1'b0;
    logic        rsp_claim, rsp_accept, rsp_retry;
    logic [31:0] rsp_rdata;
    logic        ib_req, ib_write, ib_cfg;
    logic [31:0] ib_addr, ib_wdata;
    logic [3:0]  ib_be;
    logic        ib_gnt = 1'b0;
    logic        ib_rvalid = 1'b0;
    logic [31:0] ib_rdata = '0;

    always #2.5 clk = ~clk;

    inb_txn_router dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .req_secondary(req_secondary),
        .rsp_claim(rsp_claim), .rsp_accept(rsp_accept), .rsp_retry(rsp_retry),
        .rsp_rdata(rsp_rdata),
        .ib_req(ib_req), .ib_write(ib_write), .ib_cfg(ib_cfg), .ib_addr(ib_addr),
        .ib_wdata(ib_wdata), .ib_be(ib_be), .ib_gnt(ib_gnt),
        .ib_rvalid(ib_rvalid), .ib_rdata(ib_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic [31:0] pq_addr[$];
    logic [31:0] pq_data[$];
    logic [3:0]  pq_be[$];
    logic [1:0]  rd_st = 2'd0;   // 0 empty, 1 waiting, 2 completed
    logic [3:0]  rd_cmd = '0;
    logic [31:0] rd_addr = '0;
    logic [31:0] rd_dat = '0;
    logic [1:0]  cw_st = 2'd0;
    logic [31:0] cw_addr = '0;
    logic [31:0] cw_wdat = '0;
    logic [31:0] cw_ret = '0;
    int          resp_cnt = 0;
    logic [31:0] resp_data = '0;
    bit          pend_kind = 1'b0;
    bit          last_acc = 1'b0;

    function automatic logic [31:0] cpl_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int m_path(logic [3:0] c, bit s);
        case (c)
            4'h7, 4'hF:       return 1;
            4'h6, 4'hE, 4'hC: return 2;
            4'hA:             return s ? 0 : 2;
            4'hB:             return s ? 0 : 3;
            default:          return 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [3:0] c, logic [31:0] a, logic [31:0] d, bit s, bit g);
        int          p;
        bit          pre_full;
        bit          hs;
        bit          r_acc;
        logic [34:0] e;
        string       tag;
        @(negedge clk);
        req_valid = v; req_cmd = c; req_addr = a; req_data = d;
        req_be = a[3:0] ^ 4'h9; req_secondary = s; ib_gnt = g;
        ib_rvalid = (resp_cnt == 1);
        ib_rdata  = resp_data;
        #1;
        p = m_path(c, s);
        pre_full = (pq_addr.size() >= 4);
        r_acc = 1'b0;
        if (v) begin
            e = '0;
            tag = "R1";
            case (p)
                0: tag = (s && (c == 4'hA || c == 4'hB)) ? "R2" : "R1";
                1: begin
                    tag = pre_full ? "R4" : "R3";
                    e[34] = 1'b1; e[33] = !pre_full; e[32] = pre_full;
                end
                2: begin
                    e[34] = 1'b1;
                    if (rd_st == 2'd2 && c == rd_cmd && a == rd_addr) begin
                        e[33] = 1'b1; e[31:0] = rd_dat; tag = "R5"; r_acc = 1'b1;
                    end else begin
                        e[32] = 1'b1; tag = (rd_st == 2'd0) ? "R5" : "R6";
                    end
                end
                default: begin
                    e[34] = 1'b1; tag = "R7";
                    if (cw_st == 2'd2 && a == cw_addr) begin
                        e[33] = 1'b1; e[31:0] = cw_ret; r_acc = 1'b1;
                    end else begin
                        e[32] = 1'b1;
                    end
                end
            endcase
            chk(tag, {45'd0, rsp_claim, rsp_accept, rsp_retry, rsp_rdata}, {45'd0, e});
        end
        last_acc = rsp_accept;

        // internal-bus observation
        if (ib_req) chk("R9", 80'(resp_cnt), 80'd0);
        hs = ib_req && g;
        if (hs) begin
            if (ib_write && !ib_cfg) begin
                if (pq_addr.size() == 0) begin
                    chk("R3", 80'd1, 80'd0);
                end else begin
                    chk("R3", {12'd0, ib_addr, ib_wdata, ib_be},
                              {12'd0, pq_addr[0], pq_data[0], pq_be[0]});
                    void'(pq_addr.pop_front());
                    void'(pq_data.pop_front());
                    void'(pq_be.pop_front());
                end
            end else begin
                chk("R8", 80'(pq_addr.size()), 80'd0);
                if (!ib_write) begin
                    chk("R5", {45'd0, ib_addr, ib_cfg, rd_st},
                              {45'd0, rd_addr, (rd_cmd == 4'hA), 2'd1});
                    pend_kind = 1'b0;
                end else begin
                    chk("R7", {14'd0, ib_addr, ib_wdata, cw_st},
                              {14'd0, cw_addr, cw_wdat, 2'd1});
                    pend_kind = 1'b1;
                end
            end
        end

        // model update for this edge
        if (v) begin
            case (p)
                1: if (!pre_full) begin
                    pq_addr.push_back(a); pq_data.push_back(d); pq_be.push_back(a[3:0] ^ 4'h9);
                end
                2: if (r_acc) rd_st = 2'd0;
                   else if (rd_st == 2'd0) begin rd_st = 2'd1; rd_cmd = c; rd_addr = a; end
                3: if (r_acc) cw_st = 2'd0;
                   else if (cw_st == 2'd0) begin cw_st = 2'd1; cw_addr = a; cw_wdat = d; end
                default: ;
            endcase
        end
        if (ib_rvalid) begin
            if (!pend_kind) begin rd_st = 2'd2; rd_dat = resp_data; end
            else            begin cw_st = 2'd2; cw_ret = resp_data; end
        end
        if (resp_cnt > 0) resp_cnt--;
        if (hs && !(ib_write && !ib_cfg)) begin
            resp_cnt  = 2;
            resp_data = cpl_word(ib_addr);
        end
    endtask

    task automatic idle(int n, bit g);
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, g);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000ns;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'h1BAD5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R10", {76'd0, ib_req, rsp_claim, rsp_accept, rsp_retry}, 80'd0);

        // R1 / R2: every unclaimed code on both ports leaves nothing behind
        for (int c = 0; c < 16; c++)
            for (int s = 0; s < 2; s++)
                if (m_path(4'(c), s[0]) == 0)
                    step(1'b1, 4'(c), 32'h40 + 32'(c), 32'hDEAD0000 + 32'(c), s[0], 1'b1);
        step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R1", {79'd0, ib_req}, 80'd0);

        // R3 / R4: fill the queue, overflow attempt, then drain in order
        for (int i = 0; i < 5; i++)
            step(1'b1, (i % 2) ? 4'hF : 4'h7, 32'h1000 + 32'(i * 4), 32'hA0000000 + 32'(i), 1'b0, 1'b0);
        idle(8, 1'b1);
        chk("R3", 80'(pq_addr.size()), 80'd0);

        // R8 / R5 / R6: read captured behind two posted writes
        step(1'b1, 4'h7, 32'h2000, 32'h11111111, 1'b0, 1'b0);
        step(1'b1, 4'h7, 32'h2004, 32'h22222222, 1'b0, 1'b0);
        step(1'b1, 4'h6, 32'h3000, 32'h0, 1'b0, 1'b0);
        idle(8, 1'b1);
        chk("R5", 80'(rd_st), 80'd2);
        step(1'b1, 4'h6, 32'h3004, 32'h0, 1'b0, 1'b1);   // R6 other address
        step(1'b1, 4'hE, 32'h3000, 32'h0, 1'b0, 1'b1);   // R6 other read variant
        step(1'b1, 4'h6, 32'h3000, 32'h0, 1'b0, 1'b1);
        chk("R5", {79'd0, last_acc}, 80'd1);

        // R9: writes arriving while a read is in flight wait for completion
        step(1'b1, 4'hC, 32'h3100, 32'h0, 1'b0, 1'b1);
        step(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b1);      // read granted here
        step(1'b1, 4'h7, 32'h2100, 32'h33333333, 1'b0, 1'b1);
        chk("R9", {79'd0, ib_req}, 80'd0);
        idle(6, 1'b1);
        step(1'b1, 4'hC, 32'h3100, 32'h0, 1'b0, 1'b1);
        chk("R5", {79'd0, last_acc}, 80'd1);

        // R7: configuration write, then configuration read on primary port
        step(1'b1, 4'hB, 32'h0000_0810, 32'hC0FFEE00, 1'b0, 1'b1);
        idle(6, 1'b1);
        step(1'b1, 4'hB, 32'h0000_0814, 32'h0, 1'b0, 1'b1);
        step(1'b1, 4'hB, 32'h0000_0810, 32'hC0FFEE00, 1'b0, 1'b1);
        chk("R7", {79'd0, last_acc}, 80'd1);
        step(1'b1, 4'hA, 32'h0000_0820, 32'h0, 1'b0, 1'b1);
        idle(6, 1'b1);
        step(1'b1, 4'hA, 32'h0000_0820, 32'h0, 1'b0, 1'b1);
        chk("R5", {79'd0, last_acc}, 80'd1);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int          r;
            bit          v;
            logic [3:0]  c;
            logic [31:0] a;
            r = int'($urandom % 16);
            v = 1'b1;
            a = 32'h100 + 32'(($urandom % 4) * 4);
            if (r < 5) begin
                c = ($urandom % 2) ? 4'h7 : 4'hF; a = $urandom;
            end else if (r < 9) begin
                case ($urandom % 3) 0: c = 4'h6; 1: c = 4'hE; default: c = 4'hC; endcase
            end else if (r < 11) c = 4'hA;
            else if (r < 13)     c = 4'hB;
            else if (r < 15)     c = 4'($urandom % 16);
            else begin v = 1'b0; c = 4'h0; end
            step(v, c, a, $urandom, ($urandom % 4) == 0, ($urandom % 4) != 0);
        end
        idle(20, 1'b1);
        chk("R3", 80'(pq_addr.size()), 80'd0);

        summary();
    end

endmodule